// File: doc/BRIEF.md
# Shared LED Lock Coordinator

This block is the single arbiter for a shared LED output that several processors want to drive. Each processor talks to it through its own mailbox by sending short four-byte ASCII words. A processor asks for the LED with a button message. The coordinator grants the lock and acknowledges. The holder then writes the LED through its own path and reports that it is finished with an LED-ready message. The coordinator acknowledges again, captures the LED value, and frees the lock for the next requester.

The coordinator takes at most one word per cycle from the mailboxes. When more than one mailbox offers a word in the same cycle, a rotating pointer picks which one goes first. Every word it takes gets exactly one reply word, sent back to the mailbox it came from in the next cycle. That reply is either an acknowledge or a refusal. A watchdog frees a lock whose holder never reports done and leaves a sticky flag behind. The mailbox queues and the processors are outside the block.

Top module: `lock_coordinator`

## Requirements
- R1: A message word carries byte k on bits [8k+7:8k]. Byte 0 is the type letter, 'B' (0x42) for button or 'L' (0x4C) for LED-ready. Byte 1 is the requester digit '0'+n, valid only for n < NUM_REQ. Byte 2 must be '0' (0x30). Byte 3 must be 0x00.
- R2: With the lock free, a valid button word "B<n>0" makes requester n the lock owner. The reply "A<n>A" goes to the sending mailbox one cycle after the word is taken. The reply word is byte0 'A' (0x41), byte1 the digit, byte2 'A', byte3 0x00.
- R3: With the lock held by n, a valid word "L<n>0" is answered with "A<n>A" and frees the lock in the same cycle.
- R4: On that release, led_sample holds the led_in value of the cycle the LED-ready word was taken. led_sample_valid is high for exactly one cycle, in the same cycle as the acknowledge.
- R5: With the lock held, any button word is answered with "N<n>N" (byte0 and byte2 'N' = 0x4E), and the owner and lock state do not change.
- R6: An LED-ready word whose digit is not the owner, or one that arrives while the lock is free, is answered with a refusal and leaves the lock state unchanged.
- R7: An unknown type letter, a digit outside '0'..'0'+NUM_REQ-1, a byte 2 other than '0', or a byte 3 other than 0x00 gives a refusal "N<d>N" to the sender, where d is the received byte 1 copied unchanged.
- R8: When several mailboxes offer words in the same cycle, the one at or after a rotating pointer is taken. After each word is taken, the pointer moves to the mailbox after the one served.
- R9: in_take is one-hot or zero and is high only for a mailbox that offers a word. Each word taken gives exactly one out_valid pulse, on that mailbox only, in the next cycle, and no reply appears otherwise.
- R10: A lock held for TIMEOUT cycles without a valid LED-ready word is freed without a reply, and timeout_flag sets and stays set until reset.
- R11: After reset the lock is free, out_valid and led_sample_valid are low, timeout_flag is low and the pointer favours mailbox 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_REQ | Mailbox i offers a word |
| in_data | input | NUM_REQ*32 | Offered words, mailbox i on bits [32i+31:32i] |
| in_take | output | NUM_REQ | Word of mailbox i is consumed this cycle |
| out_valid | output | NUM_REQ | Reply word for mailbox i is valid (one cycle) |
| out_data | output | NUM_REQ*32 | Reply words, mailbox i on bits [32i+31:32i] |
| led_in | input | LED_W | Current shared LED value |
| lock_busy | output | 1 | Lock is held |
| lock_owner | output | ID_W | Requester number holding the lock |
| led_sample | output | LED_W | LED value captured at release |
| led_sample_valid | output | 1 | One-cycle pulse at release |
| timeout_flag | output | 1 | Sticky: a lock was freed by the watchdog |

## Verification
The assertions assume that a mailbox keeps in_valid and its word steady until in_take takes the word. They also assume that led_in is steady around each clock edge. The bench drives each word at a falling edge and holds it until it sees in_take just after that edge. It clears in_valid only at the next falling edge, so no word is taken twice. To exercise R8, both mailboxes raise in_valid on the same falling edge, after a single-mailbox word has put the pointer in a known place.

// File: rtl/lockc_pkg.sv
package lockc_pkg;

    localparam int MSG_W = 32;

    localparam logic [7:0] CH_BUTTON = 8'h42;
    localparam logic [7:0] CH_READY  = 8'h4C;
    localparam logic [7:0] CH_ACK    = 8'h41;
    localparam logic [7:0] CH_NACK   = 8'h4E;
    localparam logic [7:0] CH_ZERO   = 8'h30;

    typedef enum logic [1:0] {
        MK_BUTTON,
        MK_READY,
        MK_BAD
    } msg_kind_e;

    // Field order follows the wire layout: byte 3 in the top bits.
    typedef struct packed {
        logic [7:0] term;
        logic [7:0] data;
        logic [7:0] digit;
        logic [7:0] letter;
    } msg_word_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [MSG_W-1:0] make_reply(input logic ok, input logic [7:0] digit);
        msg_word_t r;
        r.letter = ok ? CH_ACK : CH_NACK;
        r.digit  = digit;
        r.data   = r.letter;
        r.term   = 8'h00;
        return r;
    endfunction

endpackage

// File: rtl/lockc_decode.sv
module lockc_decode
    import lockc_pkg::*;
#(
    parameter int NUM_REQ = 2,
    parameter int ID_W    = 1
) (
    input  logic [MSG_W-1:0] word,
    output msg_kind_e        kind,
    output logic [ID_W-1:0]  id
);
    localparam logic [7:0] DIGIT_LIM = 8'(int'(CH_ZERO) + NUM_REQ);

    msg_word_t m;
    logic      framing_ok;

    assign m          = word;
    assign framing_ok = (m.term == 8'h00) && (m.data == CH_ZERO) &&
                        (m.digit >= CH_ZERO) && (m.digit < DIGIT_LIM);
    assign id         = ID_W'(m.digit - CH_ZERO);

    always_comb begin
        kind = MK_BAD;
        if (framing_ok) begin
            if (m.letter == CH_BUTTON)     kind = MK_BUTTON;
            else if (m.letter == CH_READY) kind = MK_READY;
        end
    end
endmodule

// File: rtl/lockc_rr.sv
module lockc_rr #(
    parameter int N     = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     pick,
    output logic [IDX_W-1:0] sel
);
    logic [IDX_W-1:0] ptr;

    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        sel   = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                found     = 1'b1;
                pick[idx] = 1'b1;
                sel       = IDX_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (|req) begin
            ptr <= (int'(sel) == N - 1) ? '0 : sel + 1'b1;
        end
    end
endmodule

// File: rtl/lockc_lock.sv
module lockc_lock
    import lockc_pkg::*;
#(
    parameter int ID_W    = 1,
    parameter int LED_W   = 4,
    parameter int TIMEOUT = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  msg_kind_e        kind,
    input  logic [ID_W-1:0]  id,
    input  logic [LED_W-1:0] led_in,
    output logic             ack,
    output logic             busy,
    output logic [ID_W-1:0]  owner,
    output logic [LED_W-1:0] led_sample,
    output logic             led_valid,
    output logic             timeout_flag
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             grant, done, expire;

    assign grant  = go && (kind == MK_BUTTON) && !busy;
    assign done   = go && (kind == MK_READY) && busy && (id == owner);
    assign expire = busy && !done && (hold_cnt == CNT_LAST);
    assign ack    = grant || done;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy         <= 1'b0;
            owner        <= '0;
            hold_cnt     <= '0;
            led_sample   <= '0;
            led_valid    <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            led_valid <= 1'b0;
            if (grant) begin
                busy     <= 1'b1;
                owner    <= id;
                hold_cnt <= '0;
            end else if (done) begin
                busy       <= 1'b0;
                led_sample <= led_in;
                led_valid  <= 1'b1;
            end else if (expire) begin
                busy         <= 1'b0;
                timeout_flag <= 1'b1;
            end else if (busy) begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lock_coordinator.sv
module lock_coordinator
    import lockc_pkg::*;
#(
    parameter int NUM_REQ = 2,
    parameter int LED_W   = 4,
    parameter int TIMEOUT = 1000,
    localparam int ID_W   = idx_width(NUM_REQ)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_REQ-1:0]       in_valid,
    input  logic [NUM_REQ*MSG_W-1:0] in_data,
    output logic [NUM_REQ-1:0]       in_take,
    output logic [NUM_REQ-1:0]       out_valid,
    output logic [NUM_REQ*MSG_W-1:0] out_data,
    input  logic [LED_W-1:0]         led_in,
    output logic                     lock_busy,
    output logic [ID_W-1:0]          lock_owner,
    output logic [LED_W-1:0]         led_sample,
    output logic                     led_sample_valid,
    output logic                     timeout_flag
);
    logic [NUM_REQ-1:0][MSG_W-1:0] in_arr;
    logic [NUM_REQ-1:0][MSG_W-1:0] out_arr;
    logic [ID_W-1:0]               sel;
    logic [MSG_W-1:0]              word;
    logic                          go, ack;
    msg_kind_e                     kind;
    logic [ID_W-1:0]               id;

    assign in_arr   = in_data;
    assign out_data = out_arr;
    assign go       = |in_valid;
    assign word     = in_arr[sel];

    lockc_rr #(.N(NUM_REQ), .IDX_W(ID_W)) u_rr (
        .clk  (clk),
        .rst  (rst),
        .req  (in_valid),
        .pick (in_take),
        .sel  (sel)
    );

    lockc_decode #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_dec (
        .word (word),
        .kind (kind),
        .id   (id)
    );

    lockc_lock #(.ID_W(ID_W), .LED_W(LED_W), .TIMEOUT(TIMEOUT)) u_lock (
        .clk          (clk),
        .rst          (rst),
        .go           (go),
        .kind         (kind),
        .id           (id),
        .led_in       (led_in),
        .ack          (ack),
        .busy         (lock_busy),
        .owner        (lock_owner),
        .led_sample   (led_sample),
        .led_valid    (led_sample_valid),
        .timeout_flag (timeout_flag)
    );

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_reply
        logic             v_q;
        logic [MSG_W-1:0] d_q;
        logic             mine;

        assign mine         = go && (int'(sel) == g);
        assign out_valid[g] = v_q;
        assign out_arr[g]   = d_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else begin
                v_q <= mine;
                if (mine) d_q <= make_reply(ack, word[15:8]);
            end
        end
    end
endmodule

// File: rtl/lockc_checker.sv
module lockc_checker #(
    parameter int NUM_REQ = 2,
    parameter int ID_W    = 1
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] in_valid,
    input logic [NUM_REQ-1:0] in_take,
    input logic [NUM_REQ-1:0] out_valid,
    input logic               lock_busy,
    input logic [ID_W-1:0]    lock_owner,
    input logic               led_sample_valid,
    input logic               timeout_flag
);
    a_r9_take_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_take));

    a_r9_take_offered: assert property (@(posedge clk) disable iff (rst)
        (in_take & ~in_valid) == '0);

    a_r9_one_reply: assert property (@(posedge clk) disable iff (rst)
        (|in_take) |=> ($countones(out_valid) == 1));

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(|in_take) |=> (out_valid == '0));

    a_r2_grant_replied: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_busy) |-> ($countones(out_valid) == 1));

    a_r4_sample_at_release: assert property (@(posedge clk) disable iff (rst)
        led_sample_valid |-> ($fell(lock_busy) && $countones(out_valid) == 1));

    a_r5_owner_stable: assert property (@(posedge clk) disable iff (rst)
        (lock_busy && $past(lock_busy)) |-> $stable(lock_owner));

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(timeout_flag) |-> timeout_flag);

    a_r10_silent_expire: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> ($fell(lock_busy) && out_valid == '0));
endmodule

bind lock_coordinator lockc_checker #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .in_valid         (in_valid),
    .in_take          (in_take),
    .out_valid        (out_valid),
    .lock_busy        (lock_busy),
    .lock_owner       (lock_owner),
    .led_sample_valid (led_sample_valid),
    .timeout_flag     (timeout_flag)
);

// File: tb/sim_lock_coordinator.sv
module sim_lock_coordinator;
    localparam int N  = 2;
    localparam int LW = 4;
    localparam int TO = 20;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    in_valid = '0;
    logic [N*32-1:0] in_data = '0;
    logic [N-1:0]    in_take, out_valid;
    logic [N*32-1:0] out_data;
    logic [LW-1:0]   led_in = '0;
    logic            lock_busy, led_sample_valid, timeout_flag;
    logic [0:0]      lock_owner;
    logic [LW-1:0]   led_sample;

    always #10 clk = ~clk;

    lock_coordinator #(.NUM_REQ(N), .LED_W(LW), .TIMEOUT(TO)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_take(in_take), .out_valid(out_valid), .out_data(out_data),
        .led_in(led_in), .lock_busy(lock_busy), .lock_owner(lock_owner),
        .led_sample(led_sample), .led_sample_valid(led_sample_valid),
        .timeout_flag(timeout_flag)
    );

    typedef struct {
        int          mb;
        logic [31:0] w;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 0;

    function automatic logic [31:0] mk(byte t, byte d, byte x, byte z);
        return {z, x, d, t};
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic expect_reply(int mb, logic [31:0] w, string req);
        exp_t e;
        e.mb = mb; e.w = w; e.req = req;
        q.push_back(e);
    endtask

    // Offer a word and hold it until taken; returns at the falling edge
    // after the consuming edge, where the reply is visible.
    task automatic send(int mb, logic [31:0] w);
        @(negedge clk);
        in_valid[mb] = 1'b1;
        in_data[mb*32 +: 32] = w;
        #1;
        while (!in_take[mb]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid[mb] = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                if (out_valid[i]) begin
                    if (q.size() == 0) begin
                        check(0, "R9", $sformatf("unexpected reply on mailbox %0d", i),
                              out_data[i*32 +: 32], 32'h0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(e.mb == i && out_data[i*32 +: 32] == e.w, e.req,
                              $sformatf("reply on mailbox %0d (expected mailbox %0d)", i, e.mb),
                              out_data[i*32 +: 32], e.w);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(lock_busy == 0, "R11", "lock free after reset", 32'(lock_busy), 0);
        check(out_valid == 0 && led_sample_valid == 0, "R11", "no pulses after reset",
              32'({out_valid, led_sample_valid}), 0);
        check(timeout_flag == 0, "R11", "timeout clear after reset", 32'(timeout_flag), 0);

        // R2 grant to requester 0
        expect_reply(0, mk("A", "0", "A", 0), "R2");
        send(0, mk("B", "0", "0", 0));
        check(lock_busy == 1 && lock_owner == 0, "R2", "owner 0 after button",
              32'({lock_busy, lock_owner}), 32'h2);

        // R5 button from another requester while held
        expect_reply(1, mk("N", "1", "N", 0), "R5");
        send(1, mk("B", "1", "0", 0));
        check(lock_busy == 1 && lock_owner == 0, "R5", "lock unchanged by refused button",
              32'({lock_busy, lock_owner}), 32'h2);

        // R6 LED-ready from non-owner
        expect_reply(1, mk("N", "1", "N", 0), "R6");
        send(1, mk("L", "1", "0", 0));
        check(lock_busy == 1 && lock_owner == 0, "R6", "lock unchanged by wrong ready",
              32'({lock_busy, lock_owner}), 32'h2);

        // R3 / R4 release by owner with LED sample
        led_in = 4'hA;
        expect_reply(0, mk("A", "0", "A", 0), "R3");
        send(0, mk("L", "0", "0", 0));
        check(lock_busy == 0, "R3", "lock free after ready", 32'(lock_busy), 0);
        check(led_sample_valid == 1 && led_sample == 4'hA, "R4", "sample at release",
              32'({led_sample_valid, led_sample}), 32'h1A);
        led_in = 4'h3;
        @(negedge clk);
        check(led_sample_valid == 0 && led_sample == 4'hA, "R4", "sample pulse one cycle, value held",
              32'({led_sample_valid, led_sample}), 32'h0A);

        // R6 ready while free
        expect_reply(0, mk("N", "0", "N", 0), "R6");
        send(0, mk("L", "0", "0", 0));
        check(lock_busy == 0, "R6", "ready while free leaves lock free", 32'(lock_busy), 0);

        // R7 / R1 malformed words
        expect_reply(0, mk("N", "0", "N", 0), "R7");
        send(0, mk("X", "0", "0", 0));
        expect_reply(1, mk("N", "5", "N", 0), "R7");
        send(1, mk("B", "5", "0", 0));
        expect_reply(0, mk("N", "2", "N", 0), "R1");
        send(0, mk("B", "2", "0", 0));
        expect_reply(0, mk("N", "0", "N", 0), "R1");
        send(0, mk("B", "0", "0", 8'h21));
        expect_reply(1, mk("N", "1", "N", 0), "R1");
        send(1, mk("B", "1", "7", 0));
        check(lock_busy == 0, "R7", "malformed words grant nothing", 32'(lock_busy), 0);

        // R8 simultaneous offers; the last word came from mailbox 1, so the pointer is at 0
        expect_reply(0, mk("A", "0", "A", 0), "R8");
        send(0, mk("B", "0", "0", 0)); // mailbox 0 served, pointer now 1
        expect_reply(0, mk("A", "0", "A", 0), "R3");
        send(0, mk("L", "0", "0", 0)); // pointer stays 1
        expect_reply(1, mk("A", "1", "A", 0), "R8");
        expect_reply(0, mk("N", "0", "N", 0), "R8");
        fork
            send(0, mk("B", "0", "0", 0));
            send(1, mk("B", "1", "0", 0));
        join
        check(lock_busy == 1 && lock_owner == 1, "R8", "mailbox 1 wins with pointer at 1",
              32'({lock_busy, lock_owner}), 32'h3);
        expect_reply(1, mk("A", "1", "A", 0), "R3");
        send(1, mk("L", "1", "0", 0)); // pointer now 0
        expect_reply(0, mk("A", "0", "A", 0), "R8");
        expect_reply(1, mk("N", "1", "N", 0), "R8");
        fork
            send(0, mk("B", "0", "0", 0));
            send(1, mk("B", "1", "0", 0));
        join
        check(lock_busy == 1 && lock_owner == 0, "R8", "mailbox 0 wins with pointer at 0",
              32'({lock_busy, lock_owner}), 32'h2);
        expect_reply(0, mk("A", "0", "A", 0), "R3");
        send(0, mk("L", "0", "0", 0));

        // R10 watchdog: held for exactly TO cycles
        check(timeout_flag == 0, "R10", "no timeout before stale hold", 32'(timeout_flag), 0);
        expect_reply(0, mk("A", "0", "A", 0), "R2");
        send(0, mk("B", "0", "0", 0));
        repeat (TO - 1) @(negedge clk);
        check(lock_busy == 1 && timeout_flag == 0, "R10", "still held one cycle before limit",
              32'({lock_busy, timeout_flag}), 32'h2);
        @(negedge clk);
        check(lock_busy == 0 && timeout_flag == 1, "R10", "freed with flag at limit",
              32'({lock_busy, timeout_flag}), 32'h1);
        expect_reply(0, mk("N", "0", "N", 0), "R10");
        send(0, mk("L", "0", "0", 0));
        expect_reply(1, mk("A", "1", "A", 0), "R10");
        send(1, mk("B", "1", "0", 0));
        expect_reply(1, mk("A", "1", "A", 0), "R10");
        send(1, mk("L", "1", "0", 0));
        check(timeout_flag == 1, "R10", "flag sticky after later transaction", 32'(timeout_flag), 1);

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R9", "every word replied exactly once", 32'(q.size()), 0);
        finish_run();
    end
endmodule